// File: doc/BRIEF.md
# ATA Identify Sequencer

This block runs a complete IDENTIFY DEVICE transaction on its own over a 16-bit task-file register bus. A single start strobe makes it read the device's status and error registers. It then polls status until the device is idle and ready, and confirms that no data transfer is already pending. Only then does it write the command. After the command it waits for the device to request a data transfer, and it pulls exactly 256 words into a local buffer. It finishes with a second read of status and error.

The host sees a busy flag, a one-cycle done pulse with a result code, and the status and error bytes taken before and after the transaction. It reads the captured words through a registered read port. That port can swap the two bytes of a word, because text fields hold their first character in the upper byte. Every poll loop is bounded by a host-supplied limit, so a dead or stuck device cannot hang the sequencer.

Top module: `ata_ident_seq`

## Requirements
- R1: After reset, busy_o, done_o, dev_rd_o and dev_wr_o are 0 and code_o is 0.
- R2: A start_i sampled while idle makes the block read status (address 7) and then error (address 1), one read per cycle. These two bytes appear on pre_stat_o and pre_err_o.
- R3: The block polls status once per cycle. It writes 0x00EC to address 7, exactly once, only after a poll shows busy (bit 7) clear and ready (bit 6) set, with no data request and no error.
- R4: If the first ready poll that has busy clear also shows data request (bit 3), the run ends with code 2 and no command is written.
- R5: A poll with busy clear and error (bit 0) set ends the run with code 1. A final status with bit 0 set also gives code 1.
- R6: After the command, a poll with busy clear and data request set starts the data phase. A poll with busy, ready and data request all clear ends the run with code 3.
- R7: Each wait loop has a limit L from tmo_limit_i. The (L+1)-th unsatisfied poll of one loop ends the run with code 4, so a loop that needs exactly L unsatisfied polls still succeeds.
- R8: The data phase issues exactly 256 reads of address 0. The word from the k-th read is stored in buffer entry k.
- R9: After the data phase, status and error are read again and shown on post_stat_o and post_err_o. A clean run gives code 0, with done_o due 264 cycles after the start edge when the device is idle at once and raises its data request on the second poll.
- R10: buf_data_o shows the entry at buf_addr_i one cycle after the address is applied. With buf_swap_i set, the low byte of the entry appears in bits 15:8 and the high byte in bits 7:0.
- R11: start_i has no effect while busy_o is high.
- R12: done_o is a one-cycle pulse. busy_o is low during that pulse, and code_o holds the result until the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| tmo_limit_i | input | TMO_W | Unsatisfied polls allowed per wait loop |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| code_o | output | 3 | 0 ok, 1 device error, 2 early data request, 3 bad state, 4 timeout |
| pre_stat_o | output | 8 | Status byte from the first read |
| pre_err_o | output | 8 | Error byte from the first read |
| post_stat_o | output | 8 | Status byte after the data phase |
| post_err_o | output | 8 | Error byte after the data phase |
| buf_addr_i | input | 8 | Buffer read address |
| buf_swap_i | input | 1 | Swap bytes of the read word |
| buf_data_o | output | 16 | Buffer read data, one cycle latency |
| dev_addr_o | output | 3 | Device register address |
| dev_rd_o | output | 1 | Device read strobe, data sampled on the same edge |
| dev_wr_o | output | 1 | Device write strobe |
| dev_wdata_o | output | 16 | Device write data |
| dev_rdata_i | input | 16 | Device read data |

## Verification
Each path has a fixed length, counted in clock edges from the edge that samples start. The sequence takes two capture edges, then one edge per poll. The command write takes one edge, the data phase 256 edges, and the closing reads two edges. A clean run therefore pulses done_o 264 edges after start. A ready-loop timeout with limit L pulses it after 3+L edges. Each bench task counts falling edges from start and compares the count with that figure, and it reads the buffer exactly one cycle after setting the address. The limit is tested on both sides of a device that needs exactly eight busy polls.

// File: rtl/ata_ident_pkg.sv
package ata_ident_pkg;
  localparam int STAT_BSY = 7;
  localparam int STAT_RDY = 6;
  localparam int STAT_DRQ = 3;
  localparam int STAT_ERR = 0;

  localparam logic [2:0]  REG_DATA = 3'd0;
  localparam logic [2:0]  REG_ERR  = 3'd1;
  localparam logic [2:0]  REG_CMD  = 3'd7;
  localparam logic [15:0] CMD_IDENTIFY = 16'h00EC;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_ST, S_PRE_ER, S_WT_RDY, S_ISSUE,
    S_WT_DRQ, S_XFER, S_POST_ST, S_POST_ER
  } seq_state_e;

  typedef enum logic [2:0] {
    RES_OK        = 3'd0,
    RES_DEV_ERR   = 3'd1,
    RES_EARLY_DRQ = 3'd2,
    RES_BAD_STATE = 3'd3,
    RES_TIMEOUT   = 3'd4
  } res_code_e;

  typedef enum logic [2:0] {
    V_WAIT, V_GO, V_ERR, V_EARLY, V_BAD
  } poll_verdict_e;
endpackage

// File: rtl/ata_status_eval.sv
module ata_status_eval
  import ata_ident_pkg::*;
(
  input  logic [7:0]    stat_i,
  input  logic          drq_phase_i,
  output poll_verdict_e verdict_o
);
  logic bsy, rdy, drq, err;
  assign bsy = stat_i[STAT_BSY];
  assign rdy = stat_i[STAT_RDY];
  assign drq = stat_i[STAT_DRQ];
  assign err = stat_i[STAT_ERR];

  // busy set: other bits are not valid yet
  always_comb begin
    verdict_o = V_WAIT;
    if (!bsy) begin
      if (err)              verdict_o = V_ERR;
      else if (!drq_phase_i) begin
        if (rdy && drq)     verdict_o = V_EARLY;
        else if (rdy)       verdict_o = V_GO;
      end else begin
        if (drq)            verdict_o = V_GO;
        else if (!rdy)      verdict_o = V_BAD;
      end
    end
  end
endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (tick_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ata_word_store.sv
module ata_word_store #(
  parameter int DW    = 16,
  parameter int WORDS = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(WORDS)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(WORDS)-1:0] raddr_i,
  input  logic                     swap_i,
  output logic [DW-1:0]            rdata_o
);
  localparam int NB = DW / 8;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rd_word, rd_swapped, rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rd_word = mem[raddr_i];

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign rd_swapped[b*8 +: 8] = rd_word[(NB-1-b)*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= swap_i ? rd_swapped : rd_word;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ata_ident_seq.sv
module ata_ident_seq
  import ata_ident_pkg::*;
#(
  parameter int DW    = 16,
  parameter int WORDS = 256,
  parameter int TMO_W = 16,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       code_o,
  output logic [7:0]       pre_stat_o,
  output logic [7:0]       pre_err_o,
  output logic [7:0]       post_stat_o,
  output logic [7:0]       post_err_o,
  input  logic [IW-1:0]    buf_addr_i,
  input  logic             buf_swap_i,
  output logic [DW-1:0]    buf_data_o,
  output logic [2:0]       dev_addr_o,
  output logic             dev_rd_o,
  output logic             dev_wr_o,
  output logic [DW-1:0]    dev_wdata_o,
  input  logic [DW-1:0]    dev_rdata_i
);
  seq_state_e    st_q;
  poll_verdict_e verdict;
  res_code_e     code_q;
  logic [IW-1:0] widx_q;
  logic [7:0]    stat_byte;
  logic [7:0]    pre_stat_q, pre_err_q, post_stat_q, post_err_q;
  logic          done_q, waiting, expire, tick;

  assign stat_byte = dev_rdata_i[7:0];
  assign waiting   = (st_q == S_WT_RDY) || (st_q == S_WT_DRQ);
  assign tick      = waiting && (verdict == V_WAIT);

  ata_status_eval i_eval (
    .stat_i      (stat_byte),
    .drq_phase_i (st_q == S_WT_DRQ),
    .verdict_o   (verdict)
  );

  ata_poll_timer #(.W(TMO_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (!waiting),
    .tick_i   (tick),
    .limit_i  (tmo_limit_i),
    .expire_o (expire)
  );

  ata_word_store #(.DW(DW), .WORDS(WORDS)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (st_q == S_XFER),
    .waddr_i (widx_q),
    .wdata_i (dev_rdata_i),
    .raddr_i (buf_addr_i),
    .swap_i  (buf_swap_i),
    .rdata_o (buf_data_o)
  );

  // bus strobes decoded from state
  always_comb begin
    dev_rd_o    = 1'b0;
    dev_wr_o    = 1'b0;
    dev_addr_o  = REG_DATA;
    dev_wdata_o = '0;
    unique case (st_q)
      S_PRE_ST, S_WT_RDY, S_WT_DRQ, S_POST_ST: begin
        dev_rd_o = 1'b1; dev_addr_o = REG_CMD;
      end
      S_PRE_ER, S_POST_ER: begin
        dev_rd_o = 1'b1; dev_addr_o = REG_ERR;
      end
      S_ISSUE: begin
        dev_wr_o = 1'b1; dev_addr_o = REG_CMD; dev_wdata_o = CMD_IDENTIFY;
      end
      S_XFER: begin
        dev_rd_o = 1'b1; dev_addr_o = REG_DATA;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      code_q      <= RES_OK;
      done_q      <= 1'b0;
      widx_q      <= '0;
      pre_stat_q  <= '0;
      pre_err_q   <= '0;
      post_stat_q <= '0;
      post_err_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) st_q <= S_PRE_ST;
        S_PRE_ST: begin
          pre_stat_q <= stat_byte;
          st_q       <= S_PRE_ER;
        end
        S_PRE_ER: begin
          pre_err_q <= stat_byte;
          st_q      <= S_WT_RDY;
        end
        S_WT_RDY: begin
          if (verdict == V_GO) st_q <= S_ISSUE;
          else if (verdict == V_ERR) begin
            code_q <= RES_DEV_ERR; done_q <= 1'b1; st_q <= S_IDLE;
          end else if (verdict == V_EARLY) begin
            code_q <= RES_EARLY_DRQ; done_q <= 1'b1; st_q <= S_IDLE;
          end else if (expire) begin
            code_q <= RES_TIMEOUT; done_q <= 1'b1; st_q <= S_IDLE;
          end
        end
        S_ISSUE: st_q <= S_WT_DRQ;
        S_WT_DRQ: begin
          if (verdict == V_GO) begin
            widx_q <= '0; st_q <= S_XFER;
          end else if (verdict == V_ERR) begin
            code_q <= RES_DEV_ERR; done_q <= 1'b1; st_q <= S_IDLE;
          end else if (verdict == V_BAD) begin
            code_q <= RES_BAD_STATE; done_q <= 1'b1; st_q <= S_IDLE;
          end else if (expire) begin
            code_q <= RES_TIMEOUT; done_q <= 1'b1; st_q <= S_IDLE;
          end
        end
        S_XFER: begin
          widx_q <= widx_q + 1'b1;
          if (widx_q == IW'(WORDS-1)) st_q <= S_POST_ST;
        end
        S_POST_ST: begin
          post_stat_q <= stat_byte;
          st_q        <= S_POST_ER;
        end
        S_POST_ER: begin
          post_err_q <= stat_byte;
          code_q     <= post_stat_q[STAT_ERR] ? RES_DEV_ERR : RES_OK;
          done_q     <= 1'b1;
          st_q       <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = done_q;
  assign code_o      = code_q;
  assign pre_stat_o  = pre_stat_q;
  assign pre_err_o   = pre_err_q;
  assign post_stat_o = post_stat_q;
  assign post_err_o  = post_err_q;

  // R3: command follows a clean ready poll
  a_r3_cmd_after_clean_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_wr_o |-> $past(dev_rd_o && dev_addr_o == REG_CMD && !dev_rdata_i[STAT_BSY]
                       && dev_rdata_i[STAT_RDY] && !dev_rdata_i[STAT_DRQ]
                       && !dev_rdata_i[STAT_ERR]));

  a_r3_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_rd_o && dev_wr_o));

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r12_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r11_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r7_timeout_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && code_o == RES_TIMEOUT) |-> $past(dev_rd_o && dev_addr_o == REG_CMD));
endmodule

// File: tb/test_ata_ident_seq.sv
module test_ata_ident_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] tmo_limit_i = 16'd100;
  logic        busy_o, done_o;
  logic [2:0]  code_o;
  logic [7:0]  pre_stat_o, pre_err_o, post_stat_o, post_err_o;
  logic [7:0]  buf_addr_i = '0;
  logic        buf_swap_i = 1'b0;
  logic [15:0] buf_data_o;
  logic [2:0]  dev_addr_o;
  logic        dev_rd_o, dev_wr_o;
  logic [15:0] dev_wdata_o, dev_rdata_i;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  ata_ident_seq i_ata_ident_seq (.*);

  // device model
  logic [7:0]  cfg_init = 8'h50, cfg_err = 8'h01, cfg_ready = 8'h50;
  logic [7:0]  cfg_after = 8'h58, cfg_final = 8'h50;
  logic [15:0] cfg_dly = '0, cfg_busy = '0;
  logic [7:0]  dstat = '0, derr = '0, widx = '0;
  logic [15:0] dly = '0, bcnt = '0;
  logic [1:0]  phase = '0;
  int          cmd_cnt = 0;
  logic [15:0] cmd_code = '0;

  function automatic logic [15:0] word_of(input logic [7:0] i);
    return {i ^ 8'h3C, ~i};
  endfunction

  always @(posedge clk_i) begin
    if (start_i && !busy_o) begin
      dstat <= cfg_init; derr <= cfg_err; dly <= cfg_dly; widx <= '0; phase <= 2'd0;
    end else begin
      if (phase == 2'd0 && dly != 0) begin
        dly <= dly - 1'b1;
        if (dly == 16'd1) dstat <= cfg_ready;
      end
      if (dev_wr_o && dev_addr_o == 3'd7) begin
        cmd_cnt <= cmd_cnt + 1; cmd_code <= dev_wdata_o;
        dstat <= 8'h80; bcnt <= cfg_busy; phase <= 2'd1;
      end else if (phase == 2'd1) begin
        if (bcnt == 0) begin dstat <= cfg_after; phase <= 2'd2; end
        else bcnt <= bcnt - 1'b1;
      end
      if (dev_rd_o && dev_addr_o == 3'd0) begin
        widx <= widx + 1'b1;
        if (widx == 8'd255) dstat <= cfg_final;
      end
    end
  end

  assign dev_rdata_i = (dev_addr_o == 3'd7) ? {8'h00, dstat} :
                       (dev_addr_o == 3'd1) ? {8'h00, derr} : word_of(widx);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_dev(input logic [7:0] init, input logic [15:0] d, input logic [7:0] rdy,
                         input logic [15:0] bsy, input logic [7:0] aft, input logic [7:0] fin);
    cfg_init = init; cfg_dly = d; cfg_ready = rdy;
    cfg_busy = bsy; cfg_after = aft; cfg_final = fin;
  endtask

  // returns edges from the start edge to the one that raises done_o
  task automatic run(input bit poke, output int n);
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    n = 0;
    while (!done_o && n < 5000) begin
      start_i = (poke && n == 100);
      @(negedge clk_i);
      n++;
    end
    start_i = 1'b0;
    if (n >= 5000) chk("watchdog run", 0, 1);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 rd", dev_rd_o, 0);
    chk("R1 wr", dev_wr_o, 0);
    chk("R1 code", code_o, 0);
  endtask

  task automatic t_clean;
    int n, c0;
    c0 = cmd_cnt;
    tmo_limit_i = 16'd100;
    set_dev(8'h50, 0, 8'h50, 0, 8'h58, 8'h50);
    run(0, n);
    chk("R9 latency", n, 264);
    chk("R9 code", code_o, 0);
    chk("R9 post_stat", post_stat_o, 8'h50);
    chk("R9 post_err", post_err_o, 8'h01);
    chk("R2 pre_stat", pre_stat_o, 8'h50);
    chk("R2 pre_err", pre_err_o, 8'h01);
    chk("R3 one command", cmd_cnt - c0, 1);
    chk("R3 command code", cmd_code, 16'h00EC);
    @(negedge clk_i);
    chk("R12 done one cycle", done_o, 0);
    chk("R12 code held", code_o, 0);
  endtask

  task automatic t_buffer;
    logic [7:0] a [4] = '{8'd0, 8'd1, 8'd200, 8'd255};
    for (int i = 0; i < 4; i++) begin
      buf_addr_i = a[i]; buf_swap_i = 1'b0;
      @(negedge clk_i);
      chk("R8 R10 word", buf_data_o, word_of(a[i]));
      buf_swap_i = 1'b1;
      @(negedge clk_i);
      chk("R10 swapped", buf_data_o, {word_of(a[i])[7:0], word_of(a[i])[15:8]});
    end
    buf_swap_i = 1'b0;
  endtask

  task automatic t_early_drq;
    int n, c0;
    c0 = cmd_cnt;
    set_dev(8'h58, 0, 8'h50, 0, 8'h58, 8'h50);
    run(0, n);
    chk("R4 code", code_o, 2);
    chk("R4 latency", n, 3);
    chk("R4 no command", cmd_cnt - c0, 0);
  endtask

  task automatic t_err_ready;
    int n, c0;
    c0 = cmd_cnt;
    set_dev(8'h51, 0, 8'h50, 0, 8'h58, 8'h50);
    run(0, n);
    chk("R5 code ready wait", code_o, 1);
    chk("R5 no command", cmd_cnt - c0, 0);
  endtask

  task automatic t_err_drq;
    int n;
    set_dev(8'h50, 0, 8'h50, 0, 8'h41, 8'h50);
    run(0, n);
    chk("R5 code drq wait", code_o, 1);
    chk("R5 latency", n, 6);
  endtask

  task automatic t_err_final;
    int n;
    set_dev(8'h50, 0, 8'h50, 0, 8'h58, 8'h41);
    run(0, n);
    chk("R5 final code", code_o, 1);
    chk("R5 final latency", n, 264);
    chk("R5 post_stat", post_stat_o, 8'h41);
  endtask

  task automatic t_bad_state;
    int n;
    set_dev(8'h50, 0, 8'h50, 0, 8'h00, 8'h50);
    run(0, n);
    chk("R6 code", code_o, 3);
    chk("R6 latency", n, 6);
  endtask

  task automatic t_tmo_ready;
    int n;
    set_dev(8'h80, 10, 8'h50, 0, 8'h58, 8'h50);
    tmo_limit_i = 16'd8;
    run(0, n);
    chk("R7 limit met code", code_o, 0);
    chk("R7 limit met latency", n, 272);
    chk("R2 pre_stat busy", pre_stat_o, 8'h80);
    tmo_limit_i = 16'd7;
    run(0, n);
    chk("R7 limit short code", code_o, 4);
    chk("R7 limit short latency", n, 10);
    tmo_limit_i = 16'd0;
    run(0, n);
    chk("R7 zero limit latency", n, 3);
    tmo_limit_i = 16'd100;
  endtask

  task automatic t_tmo_drq;
    int n;
    set_dev(8'h50, 0, 8'h50, 1000, 8'h58, 8'h50);
    tmo_limit_i = 16'd20;
    run(0, n);
    chk("R7 drq timeout code", code_o, 4);
    chk("R7 drq timeout latency", n, 25);
    tmo_limit_i = 16'd100;
  endtask

  task automatic t_start_busy;
    int n, c0;
    c0 = cmd_cnt;
    set_dev(8'h50, 0, 8'h50, 0, 8'h58, 8'h50);
    run(1, n);
    chk("R11 latency", n, 264);
    chk("R11 one command", cmd_cnt - c0, 1);
    chk("R11 code", code_o, 0);
    @(negedge clk_i);
    chk("R11 idle after", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_clean;
    t_buffer;
    t_early_drq;
    t_err_ready;
    t_err_drq;
    t_err_final;
    t_bad_state;
    t_tmo_ready;
    t_tmo_drq;
    t_start_busy;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule